// File: doc/BRIEF.md
# Packed-Lane Shift-and-Insert Unit

This block merges a shifted copy of a source vector into an existing destination vector, one packed lane at a time. The vector is 128 bits wide and is split into lanes of 8, 16, 32 or 64 bits. In each lane, the source is shifted left or right by an immediate amount. The bits that the shifted source occupies replace the destination bits. The destination bits in the vacated field keep their old value. A vector-width select picks the full 128-bit form or the 64-bit form. A scalar select works on lane 0 only, using a 64-bit lane. Both the 64-bit form and the scalar form clear the upper half of the result.

Shift amounts outside the legal range for the chosen lane width are clamped to the nearest legal value. The block flags each such clamp on an error output. The result and the error flag are registered. A start strobe captures a new operation, and the valid strobe rises one clock later.

The sequencer has two states. In ST_IDLE no result is fresh. A start moves it to ST_RESULT, where res_valid is high for that cycle. From ST_RESULT, a further start keeps it in ST_RESULT (back-to-back operations), and no start returns it to ST_IDLE. A synchronous reset forces ST_IDLE.

Top module: `lane_insert_unit`

## Requirements
- R1: lane_code selects the lane width: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Lane i occupies bits [i*W +: W].
- R2: With dir_right=0 (left insert), each lane result is (src << s) | (dst & low_s_ones), where low_s_ones has ones in the low s bits of the lane.
- R3: A left insert with s=0 replaces the whole lane with the source lane.
- R4: With dir_right=1 (right insert), each lane result is (src >> s, logical) | (dst & high_s_ones), where high_s_ones has ones in the top s bits of the lane.
- R5: A right insert with s equal to the lane width leaves the destination lane unchanged.
- R6: With wide_sel=0 (64-bit form), res_vec[127:64] is zero.
- R7: With scalar_sel=1, the operation uses one 64-bit lane in bits [63:0], whatever lane_code holds, and res_vec[127:64] is zero.
- R8: Legal shifts are 0..W-1 for a left insert and 1..W for a right insert. A left shift above W-1 is clamped to W-1. A right shift of 0 is clamped to 1. A right shift above W is clamped to W. Any clamp sets shift_err with the result.
- R9: res_valid is high in the cycle after each cycle in which start is high, and low otherwise. res_vec and shift_err change only on a start.
- R10: A synchronous reset clears res_vec, shift_err and res_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Capture the current operands and produce a result |
| src_vec | input | 128 | Source vector to shift |
| dst_vec | input | 128 | Current destination vector |
| lane_code | input | 2 | Lane width code (R1) |
| shift_amt | input | 7 | Immediate shift amount |
| dir_right | input | 1 | 0 = left insert, 1 = right insert |
| wide_sel | input | 1 | 1 = 128-bit form, 0 = 64-bit form |
| scalar_sel | input | 1 | 1 = scalar form on lane 0 with a 64-bit lane |
| res_vec | output | 128 | Registered merged result |
| res_valid | output | 1 | Result strobe, one clock after start |
| shift_err | output | 1 | The shift was out of range and was clamped |

## Verification
The bench targets the mask edges.
- A left shift of zero must pass the whole source lane. A design that builds the mask as ones shifted by zero would keep destination bits instead.
- A right shift of the full lane width must return the destination untouched. A shifter that wraps its amount would copy the source back in.
- A scalar operation given a small lane code must still act on a 64-bit lane and must not raise an error. A design that honours lane_code there would both mis-merge and flag a false clamp.
- Clamped shifts at both ends of the range must give the W-1 or 1 or W result and set the error. The upper half must read zero in the 64-bit and scalar forms.

// File: rtl/lane_insert_pkg.sv
package lane_insert_pkg;

    localparam int DEF_VEC_W   = 128;
    localparam int DEF_SHIFT_W = 7;
    localparam int NUM_SIZES   = 4;

    typedef enum logic [1:0] {
        LANE_B8  = 2'd0,
        LANE_B16 = 2'd1,
        LANE_B32 = 2'd2,
        LANE_B64 = 2'd3
    } lane_code_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } seq_state_e;

endpackage

// File: rtl/insert_shift_clamp.sv
module insert_shift_clamp #(
    parameter int SHIFT_W = 7
) (
    input  logic [1:0]         lane_code,
    input  logic               scalar_sel,
    input  logic               dir_right,
    input  logic [SHIFT_W-1:0] shift_in,
    output logic [1:0]         eff_code,
    output logic [SHIFT_W-1:0] shift_eff,
    output logic               out_of_range
);
    import lane_insert_pkg::*;

    logic [SHIFT_W-1:0] lane_w;

    always_comb begin
        // R7: the scalar form always uses a 64-bit lane
        eff_code     = scalar_sel ? 2'(LANE_B64) : lane_code;
        lane_w       = SHIFT_W'(8) << eff_code;
        shift_eff    = shift_in;
        out_of_range = 1'b0;
        if (!dir_right) begin
            if (shift_in > lane_w - SHIFT_W'(1)) begin
                shift_eff    = lane_w - SHIFT_W'(1);
                out_of_range = 1'b1;
            end
        end else begin
            if (shift_in == '0) begin
                shift_eff    = SHIFT_W'(1);
                out_of_range = 1'b1;
            end else if (shift_in > lane_w) begin
                shift_eff    = lane_w;
                out_of_range = 1'b1;
            end
        end
    end

    // R8: the clamped amount always lies inside the legal window
    always_comb begin
        assert_clamp_window_R8: assert (dir_right ? (shift_eff >= SHIFT_W'(1) && shift_eff <= lane_w)
                                                  : (shift_eff < lane_w));
    end

endmodule

// File: rtl/insert_lane_group.sv
module insert_lane_group #(
    parameter int VEC_W   = 128,
    parameter int LANE_W  = 8,
    parameter int SHIFT_W = 7
) (
    input  logic [VEC_W-1:0]   src_vec,
    input  logic [VEC_W-1:0]   dst_vec,
    input  logic [SHIFT_W-1:0] shift_amt,
    input  logic               dir_right,
    output logic [VEC_W-1:0]   merged
);
    localparam int LANES = VEC_W / LANE_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] src_l;
        logic [LANE_W-1:0] dst_l;
        logic [LANE_W-1:0] moved;
        logic [LANE_W-1:0] keep;
        logic [LANE_W-1:0] out_l;

        always_comb begin
            src_l = src_vec[g*LANE_W +: LANE_W];
            dst_l = dst_vec[g*LANE_W +: LANE_W];
            if (dir_right) begin
                moved = src_l >> shift_amt;
                keep  = ~({LANE_W{1'b1}} >> shift_amt);
            end else begin
                moved = src_l << shift_amt;
                keep  = ~({LANE_W{1'b1}} << shift_amt);
            end
            out_l = moved | (dst_l & keep);
        end

        assign merged[g*LANE_W +: LANE_W] = out_l;

        always_comb begin
            if (dir_right && shift_amt == SHIFT_W'(LANE_W))
                assert_keep_dst_R5: assert (out_l == dst_l);
            if (!dir_right && shift_amt == '0)
                assert_full_replace_R3: assert (out_l == src_l);
        end
    end

endmodule

// File: rtl/lane_insert_unit.sv
module lane_insert_unit #(
    parameter int VEC_W   = lane_insert_pkg::DEF_VEC_W,
    parameter int SHIFT_W = lane_insert_pkg::DEF_SHIFT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [VEC_W-1:0]   src_vec,
    input  logic [VEC_W-1:0]   dst_vec,
    input  logic [1:0]         lane_code,
    input  logic [SHIFT_W-1:0] shift_amt,
    input  logic               dir_right,
    input  logic               wide_sel,
    input  logic               scalar_sel,
    output logic [VEC_W-1:0]   res_vec,
    output logic               res_valid,
    output logic               shift_err
);
    import lane_insert_pkg::*;

    localparam int HALF_W = VEC_W / 2;

    logic [1:0]         eff_code;
    logic [SHIFT_W-1:0] shift_eff;
    logic               clamp_hit;
    logic [VEC_W-1:0]   cand [NUM_SIZES];
    logic [VEC_W-1:0]   picked;
    seq_state_e         state_q, state_nx;

    insert_shift_clamp #(.SHIFT_W(SHIFT_W)) u_clamp (
        .lane_code    (lane_code),
        .scalar_sel   (scalar_sel),
        .dir_right    (dir_right),
        .shift_in     (shift_amt),
        .eff_code     (eff_code),
        .shift_eff    (shift_eff),
        .out_of_range (clamp_hit)
    );

    // R1: one merge network per lane width
    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
        insert_lane_group #(
            .VEC_W   (VEC_W),
            .LANE_W  (8 << k),
            .SHIFT_W (SHIFT_W)
        ) u_group (
            .src_vec   (src_vec),
            .dst_vec   (dst_vec),
            .shift_amt (shift_eff),
            .dir_right (dir_right),
            .merged    (cand[k])
        );
    end

    always_comb begin
        picked = cand[eff_code];
        if (!wide_sel || scalar_sel)
            picked[VEC_W-1:HALF_W] = '0;
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_nx;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_nx = start ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_nx = start ? ST_RESULT : ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            res_vec   <= '0;
            shift_err <= 1'b0;
        end else if (start) begin
            res_vec   <= picked;
            shift_err <= clamp_hit;
        end
    end

    assign res_valid = (state_q == ST_RESULT);

    assert_valid_after_start_R9: assert property (@(posedge clk) disable iff (rst)
        start |=> res_valid);
    assert_quiet_without_start_R9: assert property (@(posedge clk) disable iff (rst)
        !start |=> !res_valid);
    assert_hold_result_R9: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(res_vec) && $stable(shift_err)));
    assert_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (start && (!wide_sel || scalar_sel)) |=> (res_vec[VEC_W-1:HALF_W] == '0));
    assert_left_overrange_R8: assert property (@(posedge clk) disable iff (rst)
        (start && !dir_right && shift_amt >= SHIFT_W'(64)) |=> shift_err);
    assert_reset_clear_R10: assert property (@(posedge clk)
        $past(rst) |-> (!res_valid && res_vec == '0 && !shift_err));

endmodule

// File: tb/tb_lane_insert_unit.sv
module tb_lane_insert_unit;

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [127:0] src_vec, dst_vec;
    logic [1:0]   lane_code;
    logic [6:0]   shift_amt;
    logic         dir_right, wide_sel, scalar_sel;
    logic [127:0] res_vec;
    logic         res_valid, shift_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    lane_insert_unit dut (
        .clk(clk), .rst(rst), .start(start),
        .src_vec(src_vec), .dst_vec(dst_vec),
        .lane_code(lane_code), .shift_amt(shift_amt),
        .dir_right(dir_right), .wide_sel(wide_sel), .scalar_sel(scalar_sel),
        .res_vec(res_vec), .res_valid(res_valid), .shift_err(shift_err)
    );

    typedef struct packed {
        logic [1:0]  code;
        logic [6:0]  sh;
        logic        rt;
        logic        wide;
        logic        sc;
        logic [31:0] sseed;
        logic [31:0] dseed;
        logic        err;
    } vec_row_t;

    // R2/R4 main patterns, R6/R7 forms, R8 clamps
    localparam int NROWS = 10;
    localparam vec_row_t TABLE [NROWS] = '{
        '{2'd0, 7'd3,  1'b0, 1'b1, 1'b0, 32'h1357_9BDF, 32'h2468_ACE0, 1'b0},
        '{2'd1, 7'd15, 1'b0, 1'b1, 1'b0, 32'hDEAD_BEEF, 32'h0F0F_3C3C, 1'b0},
        '{2'd2, 7'd31, 1'b1, 1'b1, 1'b0, 32'h8000_0001, 32'h7FFF_FFFE, 1'b0},
        '{2'd3, 7'd1,  1'b1, 1'b1, 1'b0, 32'hC001_D00D, 32'h1234_5678, 1'b0},
        '{2'd2, 7'd32, 1'b1, 1'b0, 1'b0, 32'hFFFF_0000, 32'hA5A5_5A5A, 1'b0},
        '{2'd1, 7'd20, 1'b0, 1'b1, 1'b0, 32'h0001_8001, 32'h6666_9999, 1'b1},
        '{2'd3, 7'd70, 1'b1, 1'b1, 1'b0, 32'h1111_2222, 32'h3333_4444, 1'b1},
        '{2'd0, 7'd8,  1'b1, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0102_0408, 1'b0},
        '{2'd1, 7'd5,  1'b1, 1'b0, 1'b1, 32'hCAFE_F00D, 32'h8BAD_F00D, 1'b0},
        '{2'd3, 7'd64, 1'b0, 1'b1, 1'b0, 32'h0000_00FF, 32'hFEDC_BA98, 1'b1}
    };

    function automatic logic [127:0] make_vec(input logic [31:0] seed);
        return {seed, ~seed, seed ^ 32'h5A5A_A5A5, seed[15:0], seed[31:16]};
    endfunction

    // bitwise reference: each result bit picks a destination or source bit
    function automatic logic [128:0] model(input logic [127:0] s, input logic [127:0] d,
                                           input logic [1:0] code, input int sh,
                                           input logic rt, input logic wide, input logic sc);
        int w;
        int e;
        logic err;
        logic [127:0] r;
        w = sc ? 64 : (8 << code);
        err = 1'b0;
        e = sh;
        if (!rt) begin
            if (sh > w - 1) begin e = w - 1; err = 1'b1; end
        end else begin
            if (sh < 1) begin e = 1; err = 1'b1; end
            else if (sh > w) begin e = w; err = 1'b1; end
        end
        for (int i = 0; i < 128; i++) begin
            int b;
            b = i % w;
            if (!rt) r[i] = (b < e) ? d[i] : s[i - e];
            else     r[i] = (b >= w - e) ? d[i] : s[i + e];
        end
        if (!wide || sc) r[127:64] = '0;
        return {err, r};
    endfunction

    task automatic chk_vec(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic chk_bit(input string tag, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%b exp=%b", tag, act, exp);
        end
    endtask

    // drives one operation; returns at the negedge after the capturing edge
    task automatic do_op(input logic [127:0] s, input logic [127:0] d, input logic [1:0] code,
                         input int sh, input logic rt, input logic wide, input logic sc);
        @(negedge clk);
        src_vec = s; dst_vec = d; lane_code = code; shift_amt = 7'(sh);
        dir_right = rt; wide_sel = wide; scalar_sel = sc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; start = 1'b0;
        src_vec = '0; dst_vec = '0; lane_code = '0; shift_amt = '0;
        dir_right = 1'b0; wide_sel = 1'b1; scalar_sel = 1'b0;
        repeat (3) @(negedge clk);
        chk_vec("R10 reset res_vec", res_vec, '0);
        chk_bit("R10 reset res_valid", res_valid, 1'b0);
        chk_bit("R10 reset shift_err", shift_err, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NROWS; i++) begin
            logic [127:0] s;
            logic [127:0] d;
            logic [128:0] m;
            s = make_vec(TABLE[i].sseed);
            d = make_vec(TABLE[i].dseed);
            m = model(s, d, TABLE[i].code, int'(TABLE[i].sh), TABLE[i].rt, TABLE[i].wide, TABLE[i].sc);
            do_op(s, d, TABLE[i].code, int'(TABLE[i].sh), TABLE[i].rt, TABLE[i].wide, TABLE[i].sc);
            chk_vec(TABLE[i].rt ? $sformatf("R4 row %0d", i) : $sformatf("R2 row %0d", i), res_vec, m[127:0]);
            chk_bit($sformatf("R8 row %0d err", i), shift_err, TABLE[i].err);
            chk_bit($sformatf("R9 row %0d valid", i), res_valid, 1'b1);
        end

        // R1/R2: byte lanes, left by 4: 0xAB,0xCD -> 0xBD
        do_op({16{8'hAB}}, {16{8'hCD}}, 2'd0, 4, 1'b0, 1'b1, 1'b0);
        chk_vec("R1 R2 byte left 4", res_vec, {16{8'hBD}});

        // R4/R6: byte lanes, right by 3, 64-bit form: 0xFF,0xAA -> 0xBF, upper zero
        do_op({16{8'hFF}}, {16{8'hAA}}, 2'd0, 3, 1'b1, 1'b0, 1'b0);
        chk_vec("R4 R6 byte right 3 narrow", res_vec, {64'h0, {8{8'hBF}}});

        // R5: 16-bit lanes, right by 16 keeps destination
        do_op({128{1'b1}}, {8{16'h1234}}, 2'd1, 16, 1'b1, 1'b1, 1'b0);
        chk_vec("R5 halfword right 16 keeps dst", res_vec, {8{16'h1234}});
        chk_bit("R5 no error at full width", shift_err, 1'b0);

        // R5: 64-bit lanes, right by 64 keeps destination
        do_op(make_vec(32'h0BAD_CAFE), make_vec(32'h7654_3210), 2'd3, 64, 1'b1, 1'b1, 1'b0);
        chk_vec("R5 dword right 64 keeps dst", res_vec, make_vec(32'h7654_3210));

        // R3: left by 0 replaces lanes entirely
        do_op(make_vec(32'h9876_5432), {128{1'b1}}, 2'd2, 0, 1'b0, 1'b1, 1'b0);
        chk_vec("R3 left 0 full replace", res_vec, make_vec(32'h9876_5432));

        // R7: scalar with lane_code 0 still uses a 64-bit lane; no error
        do_op({64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF}, {128{1'b1}}, 2'd0, 8, 1'b0, 1'b1, 1'b1);
        chk_vec("R7 scalar left 8", res_vec, {64'h0, 64'h2345_6789_ABCD_EFFF});
        chk_bit("R7 scalar no error", shift_err, 1'b0);

        // R8: left 9 on bytes clamps to 7
        do_op({16{8'h01}}, {16{8'h00}}, 2'd0, 9, 1'b0, 1'b1, 1'b0);
        chk_vec("R8 left clamp to 7", res_vec, {16{8'h80}});
        chk_bit("R8 left clamp error", shift_err, 1'b1);

        // R8: right 0 on bytes clamps to 1: 0x80,0xFF -> 0xC0
        do_op({16{8'h80}}, {16{8'hFF}}, 2'd0, 0, 1'b1, 1'b1, 1'b0);
        chk_vec("R8 right clamp to 1", res_vec, {16{8'hC0}});
        chk_bit("R8 right clamp error", shift_err, 1'b1);

        // R9: with no start, valid drops and the result holds
        @(negedge clk);
        chk_bit("R9 valid drops", res_valid, 1'b0);
        src_vec = '0; dst_vec = '0;
        @(negedge clk);
        chk_vec("R9 result held", res_vec, {16{8'hC0}});
        chk_bit("R9 error held", shift_err, 1'b1);

        // R10: reset after activity clears everything
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk_vec("R10 reset clears result", res_vec, '0);
        chk_bit("R10 reset clears valid", res_valid, 1'b0);
        chk_bit("R10 reset clears error", shift_err, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule